// File: doc/BRIEF.md
# Address Bounds Checker for Fault-Induced Address Corruption

This block watches the effective address of every load and store and decides whether it lands inside a region that software has declared valid. A hardware fault that corrupts an address often produces a value that still falls inside a mapped page. The page tables then raise no trap. The corrupted access goes on to damage data for a long time before any other symptom shows. This checker closes that gap. It flags any access that no live object covers.

Software supplies the valid ranges through three update ports:
- The loader writes the code limit and the global-data window once, before the application runs.
- The instrumented allocator reports each heap block as a base/size pair, and reports each release by its base.
- Function entry installs the new stack-frame limits. Function return restores the limits of the caller from a small hardware stack.

Addresses at or above the 4 GiB boundary belong to the library/reserved zone. They are always accepted.

The result for each access is registered. It appears one cycle after the access strobe as a check-valid flag and a violation pulse, together with the offending address.

Top module: `bounds_guard`

## Requirements
- R1: After reset, `chk_valid`, `viol`, `heap_ovf` and `stk_underflow` are 0. The heap table is empty, and the current stack frame is empty (low = high = 0).
- R2: A configuration write (`cfg_we`=1) sets the code region to [0, `cfg_code_end`) and the globals region to [`cfg_glob_base`, `cfg_glob_base`+`cfg_glob_size`). Accesses inside either region raise no violation. Before the first write, both regions are empty.
- R3: Any access address at or above 0x1_0000_0000 is always in bounds.
- R4: An allocation report adds the range [`alloc_base`, `alloc_base`+`alloc_size`) to the first free heap entry. Accesses inside that range are in bounds. The address `alloc_base`+`alloc_size` is not covered by the new entry.
- R5: A release invalidates every heap entry whose base equals `free_base`. A release with a base that matches no entry changes nothing.
- R6: An allocation that finds all HEAP_ENTRIES entries valid sets `heap_ovf` one cycle later. The flag stays set until reset. While it is set, heap checking is disabled: any address that misses every other region is accepted.
- R7: `call_valid` makes [`call_lo`, `call_hi`) the current frame and saves the previous frame. `ret_valid` restores the most recently saved frame. When both strobes arrive in the same cycle, the call wins and the return is ignored.
- R8: A return with no saved frame raises `stk_underflow` for exactly one cycle and leaves the current frame unchanged.
- R9: `chk_valid` and, for out-of-bounds accesses, `viol` rise exactly one cycle after `acc_valid`, each for one cycle per access. While `viol` is 1, `viol_addr` holds the checked address.
- R10: An access is judged against the state held before any configuration, allocation, release, call or return issued in the same cycle.
- R11: The hardware stack holds STACK_DEPTH saved frames. A call made while it is full drops the oldest saved frame. With STACK_DEPTH=4, five nested calls allow four good returns, and the fifth return underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write code/global bounds |
| cfg_code_end | input | 64 | Exclusive upper limit of code region |
| cfg_glob_base | input | 64 | Base of global-data region |
| cfg_glob_size | input | 64 | Size of global-data region |
| alloc_valid | input | 1 | Heap allocation report strobe |
| alloc_base | input | 64 | Base of allocated block |
| alloc_size | input | 64 | Size of allocated block |
| free_valid | input | 1 | Heap release strobe |
| free_base | input | 64 | Base of released block |
| call_valid | input | 1 | Function entry strobe |
| call_lo | input | 64 | Lowest valid stack address of new frame |
| call_hi | input | 64 | Exclusive upper stack limit of new frame |
| ret_valid | input | 1 | Function return strobe |
| acc_valid | input | 1 | Load/store address strobe |
| acc_addr | input | 64 | Effective address to check |
| chk_valid | output | 1 | Check result valid (one cycle after access) |
| viol | output | 1 | Out-of-bounds pulse |
| viol_addr | output | 64 | Address of last violation |
| heap_ovf | output | 1 | Sticky heap table overflow |
| stk_underflow | output | 1 | Return with no saved frame pulse |

## Verification
The bench probes every region at its exact edges: last byte inside and first byte outside. An off-by-one range compare would accept `base+size` or reject `base`, and that shows at once. It frees both a foreign base and a real one, to catch a release that matches the wrong entry or does nothing. It overfills the heap table and then nests calls past the stack depth. A design that never latches overflow would keep flagging heap addresses, and a stack that failed to drop its oldest entry would underflow one return late. An access issued in the same cycle as an allocation must still be judged against the old table. A design that bypassed the new entry into the lookup would miss that violation.

// File: rtl/bounds_guard_pkg.sv
package bounds_guard_pkg;
  localparam int ADDR_W = 64;
  typedef logic [ADDR_W-1:0] addr_t;

  // half-open [base, base+size), written to avoid wrap of base+size
  function automatic logic in_span(input addr_t a, input addr_t base, input addr_t size);
    return (a >= base) && ((a - base) < size);
  endfunction

  // half-open [lo, hi)
  function automatic logic in_window(input addr_t a, input addr_t lo, input addr_t hi);
    return (a >= lo) && (a < hi);
  endfunction
endpackage

// File: rtl/bg_heap_table.sv
module bg_heap_table
  import bounds_guard_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc_valid,
  input  addr_t alloc_base,
  input  addr_t alloc_size,
  input  logic  free_valid,
  input  addr_t free_base,
  input  addr_t look_addr,
  output logic  look_ok,
  output logic  ovf_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  addr_t              base_q [ENTRIES];
  addr_t              size_q [ENTRIES];
  logic               ovf_q;

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] free_match;
  logic               tbl_full;
  logic [IDX_W-1:0]   slot_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g]    = valid_q[g] && in_span(look_addr, base_q[g], size_q[g]);
    assign free_match[g] = valid_q[g] && (base_q[g] == free_base);
  end

  assign tbl_full = &valid_q;

  always_comb begin
    slot_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) slot_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ovf_q   <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else begin
      if (free_valid) valid_q <= valid_q & ~free_match;
      if (alloc_valid) begin
        if (tbl_full) begin
          ovf_q <= 1'b1;
        end else begin
          valid_q[slot_idx] <= 1'b1;
          base_q[slot_idx]  <= alloc_base;
          size_q[slot_idx]  <= alloc_size;
        end
      end
    end
  end

  assign look_ok = ovf_q | (|hit_vec);
  assign ovf_o   = ovf_q;

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  assert_full_alloc_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && tbl_full) |=> ovf_q);
  assert_free_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && (|free_match) && !alloc_valid) |=>
      ($countones(valid_q) < $past($countones(valid_q))));
  assert_alloc_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !tbl_full && !free_valid) |=>
      ($countones(valid_q) == $past($countones(valid_q)) + 1));
endmodule

// File: rtl/bg_frame_stack.sv
module bg_frame_stack
  import bounds_guard_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  call_valid,
  input  addr_t call_lo,
  input  addr_t call_hi,
  input  logic  ret_valid,
  input  addr_t look_addr,
  output logic  look_ok,
  output logic  underflow_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  addr_t            cur_lo, cur_hi;
  addr_t            sv_lo [DEPTH];
  addr_t            sv_hi [DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic             uflow_q;

  logic do_push, do_pop, bad_pop;
  assign do_push = call_valid;
  assign do_pop  = ret_valid && !call_valid && (depth_q != '0);
  assign bad_pop = ret_valid && !call_valid && (depth_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lo  <= '0;
      cur_hi  <= '0;
      depth_q <= '0;
      uflow_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        sv_lo[i] <= '0;
        sv_hi[i] <= '0;
      end
    end else begin
      uflow_q <= bad_pop;
      if (do_push) begin
        cur_lo   <= call_lo;
        cur_hi   <= call_hi;
        sv_lo[0] <= cur_lo;
        sv_hi[0] <= cur_hi;
        for (int i = 1; i < DEPTH; i++) begin
          sv_lo[i] <= sv_lo[i-1];
          sv_hi[i] <= sv_hi[i-1];
        end
        if (depth_q != CNT_W'(DEPTH)) depth_q <= depth_q + 1'b1;
      end else if (do_pop) begin
        cur_lo <= sv_lo[0];
        cur_hi <= sv_hi[0];
        for (int i = 0; i < DEPTH - 1; i++) begin
          sv_lo[i] <= sv_lo[i+1];
          sv_hi[i] <= sv_hi[i+1];
        end
        sv_lo[DEPTH-1] <= '0;
        sv_hi[DEPTH-1] <= '0;
        depth_q <= depth_q - 1'b1;
      end
    end
  end

  assign look_ok     = in_window(look_addr, cur_lo, cur_hi);
  assign underflow_o = uflow_q;

  always @(posedge clk) begin
    if (rst_n) assert_depth_bound_R11: assert (depth_q <= CNT_W'(DEPTH));
  end

  assert_underflow_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pop |=> uflow_q);
  assert_underflow_keeps_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pop |=> ($stable(cur_lo) && $stable(cur_hi)));
  assert_call_installs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |=> (cur_lo == $past(call_lo) && cur_hi == $past(call_hi)));
endmodule

// File: rtl/bounds_guard.sv
module bounds_guard
  import bounds_guard_pkg::*;
#(
  parameter int    HEAP_ENTRIES = 4,
  parameter int    STACK_DEPTH  = 4,
  parameter logic [63:0] LIB_BASE = 64'h0000_0001_0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [63:0] cfg_code_end,
  input  logic [63:0] cfg_glob_base,
  input  logic [63:0] cfg_glob_size,
  input  logic        alloc_valid,
  input  logic [63:0] alloc_base,
  input  logic [63:0] alloc_size,
  input  logic        free_valid,
  input  logic [63:0] free_base,
  input  logic        call_valid,
  input  logic [63:0] call_lo,
  input  logic [63:0] call_hi,
  input  logic        ret_valid,
  input  logic        acc_valid,
  input  logic [63:0] acc_addr,
  output logic        chk_valid,
  output logic        viol,
  output logic [63:0] viol_addr,
  output logic        heap_ovf,
  output logic        stk_underflow
);
  addr_t code_end_q, glob_base_q, glob_size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_end_q  <= '0;
      glob_base_q <= '0;
      glob_size_q <= '0;
    end else if (cfg_we) begin
      code_end_q  <= cfg_code_end;
      glob_base_q <= cfg_glob_base;
      glob_size_q <= cfg_glob_size;
    end
  end

  // named region decisions for the checker
  logic code_ok, glob_ok, lib_ok, heap_ok, frame_ok, acc_ok;

  assign code_ok = acc_addr < code_end_q;
  assign glob_ok = in_span(acc_addr, glob_base_q, glob_size_q);
  assign lib_ok  = acc_addr >= LIB_BASE;

  bg_heap_table #(.ENTRIES(HEAP_ENTRIES)) u_heap (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_valid(alloc_valid),
    .alloc_base (alloc_base),
    .alloc_size (alloc_size),
    .free_valid (free_valid),
    .free_base  (free_base),
    .look_addr  (acc_addr),
    .look_ok    (heap_ok),
    .ovf_o      (heap_ovf)
  );

  bg_frame_stack #(.DEPTH(STACK_DEPTH)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_valid (call_valid),
    .call_lo    (call_lo),
    .call_hi    (call_hi),
    .ret_valid  (ret_valid),
    .look_addr  (acc_addr),
    .look_ok    (frame_ok),
    .underflow_o(stk_underflow)
  );

  assign acc_ok = code_ok | glob_ok | lib_ok | heap_ok | frame_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_valid <= 1'b0;
      viol      <= 1'b0;
      viol_addr <= '0;
    end else begin
      chk_valid <= acc_valid;
      viol      <= acc_valid && !acc_ok;
      if (acc_valid && !acc_ok) viol_addr <= acc_addr;
    end
  end

  assert_lib_never_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr >= LIB_BASE) |=> !viol);
  assert_viol_follows_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> chk_valid);
  assert_viol_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_addr == $past(acc_addr)));
  assert_no_check_without_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !chk_valid);
endmodule

// File: tb/bounds_guard_tb.sv
module bounds_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_code_end = '0, cfg_glob_base = '0, cfg_glob_size = '0;
  logic        alloc_valid = 1'b0;
  logic [63:0] alloc_base = '0, alloc_size = '0;
  logic        free_valid = 1'b0;
  logic [63:0] free_base = '0;
  logic        call_valid = 1'b0;
  logic [63:0] call_lo = '0, call_hi = '0;
  logic        ret_valid = 1'b0;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_addr = '0;
  logic        chk_valid, viol, heap_ovf, stk_underflow;
  logic [63:0] viol_addr;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  bounds_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code_end(cfg_code_end),
    .cfg_glob_base(cfg_glob_base), .cfg_glob_size(cfg_glob_size),
    .alloc_valid(alloc_valid), .alloc_base(alloc_base), .alloc_size(alloc_size),
    .free_valid(free_valid), .free_base(free_base), .call_valid(call_valid),
    .call_lo(call_lo), .call_hi(call_hi), .ret_valid(ret_valid),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .chk_valid(chk_valid),
    .viol(viol), .viol_addr(viol_addr), .heap_ovf(heap_ovf),
    .stk_underflow(stk_underflow)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // access at one negedge, result sampled at the next
  task automatic probe(input logic [63:0] a, input logic exp_v, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    check({tag, " chk_valid"}, {63'd0, chk_valid}, 64'd1);
    check({tag, " viol"}, {63'd0, viol}, {63'd0, exp_v});
    if (exp_v) check({tag, " viol_addr"}, viol_addr, a);
  endtask

  task automatic configure(input logic [63:0] ce, input logic [63:0] gb, input logic [63:0] gs);
    @(negedge clk);
    cfg_we = 1'b1; cfg_code_end = ce; cfg_glob_base = gb; cfg_glob_size = gs;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_alloc(input logic [63:0] b, input logic [63:0] s);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_base = b; alloc_size = s;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_free(input logic [63:0] b);
    @(negedge clk);
    free_valid = 1'b1; free_base = b;
    @(negedge clk);
    free_valid = 1'b0;
  endtask

  task automatic do_call(input logic [63:0] lo, input logic [63:0] hi);
    @(negedge clk);
    call_valid = 1'b1; call_lo = lo; call_hi = hi;
    @(negedge clk);
    call_valid = 1'b0;
  endtask

  task automatic do_ret(output logic uf);
    @(negedge clk);
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
    uf = stk_underflow;
  endtask

  task automatic t_reset();
    check("R1 chk_valid", {63'd0, chk_valid}, 64'd0);
    check("R1 viol", {63'd0, viol}, 64'd0);
    check("R1 heap_ovf", {63'd0, heap_ovf}, 64'd0);
    check("R1 stk_underflow", {63'd0, stk_underflow}, 64'd0);
    probe(64'h500, 1'b1, "R2 unconfigured code");
    probe(64'h0, 1'b1, "R1 empty frame");
  endtask

  task automatic t_regions();
    configure(64'h1000, 64'h2000, 64'h100);
    probe(64'hFFF, 1'b0, "R2 code last");
    probe(64'h1000, 1'b1, "R2 code end");
    probe(64'h2000, 1'b0, "R2 glob base");
    probe(64'h20FF, 1'b0, "R2 glob last");
    probe(64'h2100, 1'b1, "R2 glob end");
    @(negedge clk);
    check("R9 viol one cycle", {63'd0, viol}, 64'd0);
    check("R9 chk_valid one cycle", {63'd0, chk_valid}, 64'd0);
  endtask

  task automatic t_lib();
    probe(64'h0000_0001_0000_0000, 1'b0, "R3 lib base");
    probe(64'h0000_0000_FFFF_FFFF, 1'b1, "R3 below lib");
    probe(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R3 top");
  endtask

  task automatic t_heap();
    probe(64'h10000, 1'b1, "R4 before alloc");
    do_alloc(64'h10000, 64'h40);
    probe(64'h10000, 1'b0, "R4 heap base");
    probe(64'h1003F, 1'b0, "R4 heap last");
    probe(64'h10040, 1'b1, "R4 heap end");
    do_free(64'h20000);
    probe(64'h10010, 1'b0, "R5 foreign free");
    do_free(64'h10000);
    probe(64'h10010, 1'b1, "R5 freed");
  endtask

  task automatic t_frames();
    logic uf;
    do_call(64'h8000, 64'h8100);
    probe(64'h80FF, 1'b0, "R7 frame1 last");
    probe(64'h8100, 1'b1, "R7 frame1 end");
    do_call(64'h7000, 64'h7080);
    probe(64'h7000, 1'b0, "R7 frame2");
    probe(64'h8000, 1'b1, "R7 caller hidden");
    do_ret(uf);
    check("R7 ret no underflow", {63'd0, uf}, 64'd0);
    probe(64'h8000, 1'b0, "R7 caller restored");
    probe(64'h7000, 1'b1, "R7 callee gone");
    do_ret(uf);
    probe(64'h8000, 1'b1, "R7 back to empty");
    do_ret(uf);
    check("R8 underflow pulse", {63'd0, uf}, 64'd1);
    @(negedge clk);
    check("R8 underflow one cycle", {63'd0, stk_underflow}, 64'd0);
  endtask

  task automatic t_deep();
    logic uf;
    for (int i = 1; i <= 5; i++) do_call(64'h9000 + 64'(i) * 64'h100, 64'h9100 + 64'(i) * 64'h100);
    probe(64'h9500, 1'b0, "R11 frame5");
    for (int i = 4; i >= 1; i--) begin
      do_ret(uf);
      check("R11 good return", {63'd0, uf}, 64'd0);
      probe(64'h9000 + 64'(i) * 64'h100, 1'b0, "R11 restored frame");
    end
    do_ret(uf);
    check("R11 fifth return underflows", {63'd0, uf}, 64'd1);
    probe(64'h9100, 1'b0, "R8 frame kept after underflow");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    alloc_valid = 1'b1; alloc_base = 64'h30000; alloc_size = 64'h10;
    acc_valid = 1'b1; acc_addr = 64'h30000;
    @(negedge clk);
    alloc_valid = 1'b0; acc_valid = 1'b0;
    check("R10 old table used", {63'd0, viol}, 64'd1);
    probe(64'h30000, 1'b0, "R10 new entry later");
    @(negedge clk);
    call_valid = 1'b1; call_lo = 64'hA000; call_hi = 64'hA100; ret_valid = 1'b1;
    @(negedge clk);
    call_valid = 1'b0; ret_valid = 1'b0;
    check("R7 call wins no underflow", {63'd0, stk_underflow}, 64'd0);
    probe(64'hA000, 1'b0, "R7 call wins frame");
  endtask

  task automatic t_overflow();
    do_alloc(64'h40000, 64'h10);
    do_alloc(64'h50000, 64'h10);
    do_alloc(64'h60000, 64'h10);
    check("R6 full no ovf", {63'd0, heap_ovf}, 64'd0);
    probe(64'h70000, 1'b1, "R6 before overflow");
    probe(64'h60000, 1'b0, "R4 fourth entry");
    do_alloc(64'h70000, 64'h10);
    check("R6 ovf set", {63'd0, heap_ovf}, 64'd1);
    probe(64'h70000, 1'b1 ^ 1'b1, "R6 heap check off");
    probe(64'h88888, 1'b0, "R6 any heap addr passes");
    do_free(64'h40000);
    check("R6 ovf sticky", {63'd0, heap_ovf}, 64'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regions();
    t_lib();
    t_heap();
    t_frames();
    t_deep();
    t_same_cycle();
    t_overflow();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule